// File: doc/BRIEF.md
# Folded Row-Column Read/Write Memory

A small synchronous read/write store of eight 4-bit words whose cells are arranged as four physical rows of eight bits. Two logical words share each row. The upper address bits go to a one-hot row decoder, and the lowest address bit goes to a column selector that chooses the low or the high nibble of that row. A write changes only the chosen nibble. A read copies the chosen nibble into an output register.

An access happens only while the select input is high. The access-kind input then chooses between storing the write data and fetching a word. Read data appears one clock after the request, together with a valid flag. Whenever the flag is low the data output is held at zero, so it drives nothing onto a shared OR-combined bus. All storage clears to zero on a synchronous reset.

Top module: `fold_mem`

## Requirements
- R1: While `rst` is high at a clock edge, every stored word becomes 0 and `rd_valid` becomes 0. After reset, a read of any address returns 0.
- R2: Address bits `[2:1]` select one of four rows, and bit `[0]` selects the half: 0 is row bits 3:0 and 1 is row bits 7:4. All eight addresses name distinct words.
- R3: A clock edge with `sel=1` and `wr_en=1` stores `wr_data` into the word at `addr`. A later read of that address returns it.
- R4: A write changes only its own half-row. The word at `addr ^ 1` in the same row keeps its value, and all other rows stay unchanged.
- R5: An edge with `sel=0` performs no access: no word changes, whatever `wr_en`, `addr` and `wr_data` hold, and `rd_valid` is 0 after that edge.
- R6: An edge with `sel=1` and `wr_en=0` makes `rd_valid=1` and `rd_data` equal to the addressed word after that same edge, for one cycle. Back-to-back reads each deliver their own word.
- R7: `rd_data` is 0 whenever `rd_valid` is 0.
- R8: A write edge leaves `rd_valid` at 0 after it.
- R9: A read on the edge after a write to the same address returns the newly written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel | input | 1 | Access enable; gates both decoders |
| wr_en | input | 1 | 1 = store, 0 = fetch |
| addr | input | 3 | Word address: row in [2:1], half in [0] |
| wr_data | input | 4 | Word to store |
| rd_data | output | 4 | Fetched word; 0 when not valid |
| rd_valid | output | 1 | Fetched word present this cycle |

## Verification
On every cycle, the assertions check that the row and column selects are at most one-hot and are empty while `sel` is low. They also check that a write leaves the unselected half and the other rows untouched, that `rd_valid` follows a read request by exactly one edge, and that the output is zero while not valid. Only the bench scenarios can show that the values are correct. These are the readback of a distinct word at each address, that the address bits map to distinct storage, that a same-address read after a write returns the new data, and that reset clears the contents.

// File: rtl/fold_mem_pkg.sv
package fold_mem_pkg;
  typedef enum logic {
    ACC_FETCH = 1'b0,
    ACC_STORE = 1'b1
  } acc_kind_e;

  localparam int DEF_ADDR_W   = 3;
  localparam int DEF_WORD_W   = 4;
  localparam int DEF_COL_BITS = 1;
endpackage

// File: rtl/fold_row_dec.sv
module fold_row_dec #(
  parameter int ROW_BITS = 2,
  localparam int ROWS = 2 ** ROW_BITS
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en,
  input  logic [ROW_BITS-1:0] row_idx,
  output logic [ROWS-1:0]     row_sel
);
  always_comb begin
    row_sel = '0;
    for (int r = 0; r < ROWS; r++) begin
      if (en && (row_idx == ROW_BITS'(r))) row_sel[r] = 1'b1;
    end
  end

  // R2: at most one row is active
  a_r2_row_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(row_sel));
  // R5: no row is active without the enable
  a_r5_no_row_idle: assert property (@(posedge clk) disable iff (rst)
    !en |-> (row_sel == '0));
endmodule

// File: rtl/fold_col_sel.sv
module fold_col_sel #(
  parameter int COL_BITS = 1,
  parameter int WORD_W   = 4,
  localparam int WPR   = 2 ** COL_BITS,
  localparam int ROW_W = WORD_W * WPR
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en,
  input  logic [COL_BITS-1:0] col_idx,
  output logic [WPR-1:0]      col_sel,
  output logic [ROW_W-1:0]    lane_mask
);
  for (genvar c = 0; c < WPR; c++) begin : g_col
    assign col_sel[c] = en && (col_idx == COL_BITS'(c));
    assign lane_mask[c*WORD_W +: WORD_W] = {WORD_W{col_sel[c]}};
  end

  // R2: one half at most
  a_r2_col_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(col_sel));
  // R4: the lane mask covers exactly one word when enabled
  a_r4_mask_width: assert property (@(posedge clk) disable iff (rst)
    en |-> ($countones(lane_mask) == WORD_W));
endmodule

// File: rtl/fold_row_bank.sv
module fold_row_bank #(
  parameter int ROWS   = 4,
  parameter int WORD_W = 4,
  parameter int WPR    = 2,
  localparam int ROW_W = WORD_W * WPR
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ROWS-1:0]   row_sel,
  input  logic [ROW_W-1:0]  lane_mask,
  input  logic [WORD_W-1:0] wr_word,
  output logic [ROW_W-1:0]  rd_row
);
  logic [ROW_W-1:0] row_q [ROWS];
  logic [ROW_W-1:0] wr_row;

  assign wr_row = {WPR{wr_word}};

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    always_ff @(posedge clk) begin
      if (rst) begin
        row_q[r] <= '0;
      end else if (we && row_sel[r]) begin
        row_q[r] <= (row_q[r] & ~lane_mask) | (wr_row & lane_mask);
      end
    end

    // R4: bits outside the written half keep their value
    a_r4_other_half_kept: assert property (@(posedge clk) disable iff (rst)
      (we && row_sel[r]) |=>
        ((row_q[r] & ~$past(lane_mask)) == ($past(row_q[r]) & ~$past(lane_mask))));
    // R4/R5: rows not written stay unchanged
    a_r5_unwritten_stable: assert property (@(posedge clk) disable iff (rst)
      !(we && row_sel[r]) |=> $stable(row_q[r]));
  end

  always_comb begin
    rd_row = '0;
    for (int r = 0; r < ROWS; r++) begin
      rd_row = rd_row | (row_q[r] & {ROW_W{row_sel[r]}});
    end
  end
endmodule

// File: rtl/fold_out_drv.sv
module fold_out_drv #(
  parameter int WORD_W = 4,
  parameter int WPR    = 2,
  localparam int ROW_W = WORD_W * WPR
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_req,
  input  logic [WPR-1:0]    col_sel,
  input  logic [ROW_W-1:0]  rd_row,
  output logic [WORD_W-1:0] rd_data,
  output logic              rd_valid
);
  logic [WORD_W-1:0] word_mux;

  always_comb begin
    word_mux = '0;
    for (int c = 0; c < WPR; c++) begin
      word_mux = word_mux | (rd_row[c*WORD_W +: WORD_W] & {WORD_W{col_sel[c]}});
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_req;
      rd_data  <= rd_req ? word_mux : '0;
    end
  end
endmodule

// File: rtl/fold_mem.sv
module fold_mem
  import fold_mem_pkg::*;
#(
  parameter int ADDR_W   = DEF_ADDR_W,
  parameter int WORD_W   = DEF_WORD_W,
  parameter int COL_BITS = DEF_COL_BITS,
  localparam int ROW_BITS = ADDR_W - COL_BITS,
  localparam int ROWS     = 2 ** ROW_BITS,
  localparam int WPR      = 2 ** COL_BITS,
  localparam int ROW_W    = WORD_W * WPR
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] rd_data,
  output logic              rd_valid
);
  acc_kind_e        kind;
  logic [ROWS-1:0]  row_sel;
  logic [WPR-1:0]   col_sel;
  logic [ROW_W-1:0] lane_mask;
  logic [ROW_W-1:0] rd_row;
  logic             do_store;
  logic             do_fetch;

  assign kind     = acc_kind_e'(wr_en);
  assign do_store = sel && (kind == ACC_STORE);
  assign do_fetch = sel && (kind == ACC_FETCH);

  fold_row_dec #(.ROW_BITS(ROW_BITS)) u_row_dec (
    .clk(clk), .rst(rst), .en(sel),
    .row_idx(addr[ADDR_W-1:COL_BITS]), .row_sel(row_sel)
  );

  fold_col_sel #(.COL_BITS(COL_BITS), .WORD_W(WORD_W)) u_col_sel (
    .clk(clk), .rst(rst), .en(sel),
    .col_idx(addr[COL_BITS-1:0]), .col_sel(col_sel), .lane_mask(lane_mask)
  );

  fold_row_bank #(.ROWS(ROWS), .WORD_W(WORD_W), .WPR(WPR)) u_bank (
    .clk(clk), .rst(rst), .we(do_store), .row_sel(row_sel),
    .lane_mask(lane_mask), .wr_word(wr_data), .rd_row(rd_row)
  );

  fold_out_drv #(.WORD_W(WORD_W), .WPR(WPR)) u_out (
    .clk(clk), .rst(rst), .rd_req(do_fetch), .col_sel(col_sel),
    .rd_row(rd_row), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  // R6: a fetch request yields valid data one edge later
  a_r6_valid_after_read: assert property (@(posedge clk) disable iff (rst)
    (sel && !wr_en) |=> rd_valid);
  // R5/R8: no valid without a fetch request
  a_r8_no_valid_otherwise: assert property (@(posedge clk) disable iff (rst)
    !(sel && !wr_en) |=> !rd_valid);
  // R7: the output is not driven while not valid
  a_r7_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !rd_valid |-> (rd_data == '0));
endmodule

// File: tb/fold_mem_bench.sv
module fold_mem_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sel = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] addr = '0;
  logic [3:0] wr_data = '0;
  logic [3:0] rd_data;
  logic       rd_valid;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  logic [3:0] model [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  fold_mem u_fold_mem (
    .clk(clk), .rst(rst), .sel(sel), .wr_en(wr_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step_cycle(logic s, logic w, logic [2:0] a, logic [3:0] d);
    @(negedge clk);
    sel = s; wr_en = w; addr = a; wr_data = d;
    @(posedge clk);
    #1;
  endtask

  task automatic do_write(logic [2:0] a, logic [3:0] d);
    step_cycle(1'b1, 1'b1, a, d);
    model[a] = d;
  endtask

  task automatic do_read(string req, logic [2:0] a);
    step_cycle(1'b1, 1'b0, a, 4'h0);
    check({req, " valid"}, {7'd0, rd_valid}, 8'd1);
    check({req, " data"}, {4'd0, rd_data}, {4'd0, model[a]});
  endtask

  task automatic do_idle();
    step_cycle(1'b0, 1'b0, 3'd0, 4'h0);
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst = 1'b1; sel = 1'b0;
    @(posedge clk); @(posedge clk);
    #1;
    for (int i = 0; i < 8; i++) model[i] = 4'h0;
    check("R1 valid after reset", {7'd0, rd_valid}, 8'd0);
    check("R7 data after reset", {4'd0, rd_data}, 8'd0);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset_clear();
    apply_reset();
    for (int i = 0; i < 8; i++) do_read("R1 cleared word", 3'(i));
    do_idle();
  endtask

  task automatic t_all_words();
    for (int i = 0; i < 8; i++) do_write(3'(i), 4'(i * 3 + 5));
    check("R8 valid after write", {7'd0, rd_valid}, 8'd0);
    check("R7 data after write", {4'd0, rd_data}, 8'd0);
    for (int i = 0; i < 8; i++) do_read("R3 R2 readback", 3'(i));
    do_idle();
    check("R6 valid lasts one cycle", {7'd0, rd_valid}, 8'd0);
  endtask

  task automatic t_half_keep();
    do_write(3'd2, 4'hA);
    do_write(3'd3, 4'h5);
    do_write(3'd2, 4'hF);
    do_read("R4 neighbour kept", 3'd3);
    do_read("R4 own half", 3'd2);
    do_write(3'd7, 4'h0);
    do_read("R4 low half of row 3", 3'd6);
    do_read("R4 other row", 3'd0);
  endtask

  task automatic t_sel_low();
    step_cycle(1'b0, 1'b1, 3'd4, 4'h9);
    check("R5 no valid on idle write", {7'd0, rd_valid}, 8'd0);
    step_cycle(1'b0, 1'b0, 3'd4, 4'h0);
    check("R5 no valid on idle read", {7'd0, rd_valid}, 8'd0);
    check("R7 zero while idle", {4'd0, rd_data}, 8'd0);
    do_read("R5 word unchanged", 3'd4);
  endtask

  task automatic t_read_after_write();
    do_write(3'd6, 4'hC);
    do_read("R9 same address next edge", 3'd6);
    do_write(3'd1, 4'h3);
    do_read("R9 odd address", 3'd1);
    do_read("R9 even neighbour", 3'd0);
    do_idle();
  endtask

  initial begin
    for (int i = 0; i < 8; i++) model[i] = 4'h0;
    t_reset_clear();
    t_all_words();
    t_half_keep();
    t_sel_low();
    t_read_after_write();
    apply_reset();
    for (int i = 0; i < 8; i++) do_read("R1 reset mid-run", 3'(i));
    do_idle();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule